// File: doc/BRIEF.md
# Cartridge Bus ROM Emulation Bridge

This block lets a game console fetch words of a cartridge ROM image that is stored in SDRAM. On the console side it sees an asynchronous 22-bit word address, an active-low read strobe, an active-low range select and a presence level. Presence is high only while the cartridge is seated in a powered console. On the memory side it drives a simple read port of an existing SDRAM controller. That port has a ready level, a one-cycle request, a 24-bit word address and a one-cycle data-valid pulse with 16-bit data.

All console inputs pass through a chain of synchronizer flops before any logic looks at them. When a read strobe is seen while the cartridge is present, the bridge captures the address and masks it, so that a small image is mirrored across the whole console space. It then waits for the controller to be ready and issues exactly one read. It latches the returned word and holds it on the console data lines until the strobe is released. It also produces the output-disable for the external level-shifting transceiver. The disable keeps the console data pins high-impedance except during an active read. A parameter bit adds the range select to both the start condition and the disable.

Top module: `cart_rom_bridge`

## Requirements
- R1: While reset is held and directly after it, cartDataDisable is 1 and memReq is 0.
- R2: With RANGE_GATE=0, cartDataDisable is 0 only while the synchronized presence is 1 and the synchronized read strobe is 0. Once the strobe returns high, cartDataDisable is 1 again within 3 clock cycles.
- R3: While presence is 0, no read is ever requested. A presence drop in any non-idle state sends the controller back to idle on the next clock, so a read that was waiting for ready is abandoned without a request.
- R4: memReq is raised only in the cycle after memReady was seen high, and it lasts exactly one cycle.
- R5: Each assertion of the read strobe produces exactly one memReq, however long the strobe stays low.
- R6: memAddr equals the synchronized console address ANDed with ADDR_MASK (default 0x3FFFF) and zero-extended to 24 bits. For example, 0x0ABCDE maps to 0x02BCDE.
- R7: The 16-bit word that arrives with memValid after a request is driven on cartData. It does not change while the transceiver stays enabled.
- R8: With RANGE_GATE=0 the range select has no effect. With RANGE_GATE=1, a read starts only while the range select is also low, and cartDataDisable stays 1 while the range select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rstN | input | 1 | Active-low synchronous reset |
| cartAddr | input | 22 | Console word address, asynchronous |
| cartReadN | input | 1 | Console read strobe, active low, asynchronous |
| cartRangeN | input | 1 | Console range select, active low, asynchronous |
| cartPresent | input | 1 | High while seated in a powered console |
| cartData | output | 16 | Word driven toward the console through the transceiver |
| cartDataDisable | output | 1 | Transceiver output-disable, 1 = high impedance |
| memReq | output | 1 | One-cycle read request to the SDRAM controller |
| memAddr | output | 24 | Word address of the request |
| memReady | input | 1 | Controller can accept a request |
| memValid | input | 1 | One-cycle pulse marking memData valid |
| memData | input | 16 | Read data from the controller |

## Verification
The assertions assume that the console holds the address steady from before the strobe falls until after the strobe rises. They also assume that the controller returns one data-valid pulse for each request, never in the same cycle as the request. They further assume that presence can drop at any time. The stimulus changes console inputs only on falling clock edges and sets the address together with the strobe. The memory model answers each request with a single valid pulse one cycle later. Busy intervals are imposed only through the ready level.

// File: rtl/cart_bridge_pkg.sv
package cart_bridge_pkg;

  typedef enum logic [1:0] {
    ST_IDLE       = 2'd0,
    ST_WAIT_READY = 2'd1,
    ST_ISSUE      = 2'd2,
    ST_WAIT_DONE  = 2'd3
  } bridgeState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic takeAddr;
    logic takeData;
    logic issueReq;
  } ctlStrobes_t;

endpackage

// File: rtl/cart_bus_sync.sv
module cart_bus_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);

  logic [WIDTH-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rstN) chain[g] <= RESET_VAL;
        else       chain[g] <= dIn;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rstN) chain[g] <= RESET_VAL;
        else       chain[g] <= chain[g-1];
      end
    end
  end

  assign dOut = chain[STAGES-1];

endmodule

// File: rtl/cart_bridge_ctrl.sv
module cart_bridge_ctrl
  import cart_bridge_pkg::*;
#(
  parameter bit RANGE_GATE = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        presentS,
  input  logic        readNS,
  input  logic        rangeNS,
  input  logic        memReady,
  input  logic        memValid,
  output ctlStrobes_t strobes,
  output logic        dataDisable
);

  bridgeState_t state, stateNext;
  logic rangeOk;
  logic startCond;
  logic reqSinceIdle;

  assign rangeOk   = RANGE_GATE ? ~rangeNS : 1'b1;
  assign startCond = presentS & ~readNS & rangeOk;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:       if (startCond) stateNext = ST_WAIT_READY;
      ST_WAIT_READY: begin
        if (!presentS)     stateNext = ST_IDLE;
        else if (memReady) stateNext = ST_ISSUE;
      end
      ST_ISSUE:      stateNext = presentS ? ST_WAIT_DONE : ST_IDLE;
      ST_WAIT_DONE:  if (!presentS || readNS) stateNext = ST_IDLE;
      default:       stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobes.takeAddr = (state == ST_IDLE) && startCond;
    strobes.issueReq = (state == ST_ISSUE);
    strobes.takeData = memValid && (state == ST_WAIT_DONE || state == ST_ISSUE);
  end

  assign dataDisable = ~startCond;

  always_ff @(posedge clk) begin
    if (!rstN)                 reqSinceIdle <= 1'b0;
    else if (state == ST_IDLE) reqSinceIdle <= 1'b0;
    else if (strobes.issueReq) reqSinceIdle <= 1'b1;
  end

  p_drop_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && !presentS) |=> state == ST_IDLE);

  p_req_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.issueReq |=> !strobes.issueReq);

  p_req_ready_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.issueReq |-> $past(memReady));

  p_one_req_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.issueReq |-> !reqSinceIdle);

endmodule

// File: rtl/cart_bridge_dp.sv
module cart_bridge_dp
  import cart_bridge_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int MEM_ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] ADDR_MASK = 22'h3FFFF
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctlStrobes_t           strobes,
  input  logic [ADDR_W-1:0]     addrS,
  input  logic [DATA_W-1:0]     memData,
  output logic [MEM_ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0]     busData
);

  localparam int PAD_W = MEM_ADDR_W - ADDR_W;

  logic [ADDR_W-1:0] addrReg;

  always_ff @(posedge clk) begin
    if (!rstN)                 addrReg <= '0;
    else if (strobes.takeAddr) addrReg <= addrS & ADDR_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 busData <= '0;
    else if (strobes.takeData) busData <= memData;
  end

  assign memAddr = {{PAD_W{1'b0}}, addrReg};

  p_addr_mask_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.issueReq |-> (memAddr[ADDR_W-1:0] & ~ADDR_MASK) == '0
                         && memAddr[MEM_ADDR_W-1:ADDR_W] == '0);

endmodule

// File: rtl/cart_rom_bridge.sv
module cart_rom_bridge
  import cart_bridge_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int MEM_ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] ADDR_MASK = 22'h3FFFF,
  parameter bit RANGE_GATE = 1'b0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     cartAddr,
  input  logic                  cartReadN,
  input  logic                  cartRangeN,
  input  logic                  cartPresent,
  output logic [DATA_W-1:0]     cartData,
  output logic                  cartDataDisable,
  output logic                  memReq,
  output logic [MEM_ADDR_W-1:0] memAddr,
  input  logic                  memReady,
  input  logic                  memValid,
  input  logic [DATA_W-1:0]     memData
);

  localparam int CTL_W = 3;

  logic [ADDR_W-1:0] addrS;
  logic [CTL_W-1:0]  ctlS;
  ctlStrobes_t       strobes;

  cart_bus_sync #(.WIDTH(ADDR_W), .STAGES(SYNC_STAGES), .RESET_VAL('0)) u_addrSync (
    .clk(clk), .rstN(rstN), .dIn(cartAddr), .dOut(addrS));

  // {present, readN, rangeN}; idle levels at reset
  cart_bus_sync #(.WIDTH(CTL_W), .STAGES(SYNC_STAGES), .RESET_VAL(3'b011)) u_ctlSync (
    .clk(clk), .rstN(rstN), .dIn({cartPresent, cartReadN, cartRangeN}), .dOut(ctlS));

  cart_bridge_ctrl #(.RANGE_GATE(RANGE_GATE)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .presentS(ctlS[2]), .readNS(ctlS[1]), .rangeNS(ctlS[0]),
    .memReady(memReady), .memValid(memValid),
    .strobes(strobes), .dataDisable(cartDataDisable));

  cart_bridge_dp #(.ADDR_W(ADDR_W), .MEM_ADDR_W(MEM_ADDR_W), .DATA_W(DATA_W),
                   .ADDR_MASK(ADDR_MASK)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .addrS(addrS),
    .memData(memData), .memAddr(memAddr), .busData(cartData));

  assign memReq = strobes.issueReq;

  p_data_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!cartDataDisable && $past(!cartDataDisable) && !$past(memValid)) |-> $stable(cartData));

endmodule

// File: tb/cart_rom_bridge_tb.sv
module cart_rom_bridge_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [21:0] cartAddr = '0;
  logic        cartReadN = 1'b1;
  logic        cartRangeN = 1'b1;
  logic        cartPresent = 1'b0;
  logic [15:0] cartData;
  logic        cartDataDisable;
  logic        memReq;
  logic [23:0] memAddr;
  logic        memReady;
  logic        memValid = 1'b0;
  logic [15:0] memData = '0;

  logic [15:0] dataR;
  logic        disableR, reqR;
  logic [23:0] addrR;

  int testsRun = 0, testsFailed = 0;
  int reqCount = 0, reqCountR = 0;
  int busyLeft = 0;
  logic [23:0] lastAddr = '0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign memReady = (busyLeft == 0);

  cart_rom_bridge u_dut (
    .clk(clk), .rstN(rstN), .cartAddr(cartAddr), .cartReadN(cartReadN),
    .cartRangeN(cartRangeN), .cartPresent(cartPresent), .cartData(cartData),
    .cartDataDisable(cartDataDisable), .memReq(memReq), .memAddr(memAddr),
    .memReady(memReady), .memValid(memValid), .memData(memData));

  cart_rom_bridge #(.RANGE_GATE(1'b1)) u_dutRange (
    .clk(clk), .rstN(rstN), .cartAddr(cartAddr), .cartReadN(cartReadN),
    .cartRangeN(cartRangeN), .cartPresent(cartPresent), .cartData(dataR),
    .cartDataDisable(disableR), .memReq(reqR), .memAddr(addrR),
    .memReady(1'b1), .memValid(1'b0), .memData(16'h0000));

  function automatic logic [15:0] romWord(logic [23:0] a);
    return a[15:0] ^ {a[23:16], 8'h00} ^ 16'h5A3C;
  endfunction

  // memory model: one valid pulse one cycle after each request
  always @(posedge clk) begin
    if (busyLeft > 0) busyLeft <= busyLeft - 1;
    memValid <= memReq;
    memData  <= romWord(memAddr);
    if (memReq) begin
      reqCount <= reqCount + 1;
      lastAddr <= memAddr;
    end
    if (reqR) reqCountR <= reqCountR + 1;
  end

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // {addr22, busy8, hold12, expAddr24}
  localparam int NVEC = 8;
  localparam logic [65:0] VECS [NVEC] = '{
    {22'h000000, 8'd0, 12'd20,  24'h000000},
    {22'h012345, 8'd0, 12'd20,  24'h012345},
    {22'h0ABCDE, 8'd2, 12'd24,  24'h02BCDE},
    {22'h3FFFFF, 8'd0, 12'd20,  24'h03FFFF},
    {22'h03FFFF, 8'd5, 12'd30,  24'h03FFFF},
    {22'h040000, 8'd0, 12'd20,  24'h000000},
    {22'h2C0001, 8'd9, 12'd40,  24'h000001},
    {22'h1FFFFE, 8'd0, 12'd200, 24'h03FFFE}
  };

  task automatic runRead(logic [21:0] a, int busy, int hold, logic [23:0] expA);
    int startCount;
    logic [15:0] first;
    @(negedge clk);
    startCount = reqCount;
    busyLeft = busy;
    cartAddr = a;
    cartReadN = 1'b0;
    if (busy >= 5) begin
      repeat (4) @(negedge clk);
      check(reqCount == startCount, "R4 no request while not ready", reqCount - startCount, 0);
      repeat (hold - 4) @(negedge clk);
    end else begin
      repeat (hold) @(negedge clk);
    end
    check(cartDataDisable == 1'b0, "R2 enabled during read", cartDataDisable, 0);
    check(reqCount - startCount == 1, "R5 one request per strobe", reqCount - startCount, 1);
    check(lastAddr == expA, "R6 masked address", lastAddr, expA);
    first = cartData;
    repeat (3) @(negedge clk);
    check(cartData == romWord(expA) && cartData == first, "R7 latched word held",
          cartData, romWord(expA));
    cartReadN = 1'b1;
    repeat (3) @(negedge clk);
    check(cartDataDisable == 1'b1, "R2 disabled after release", cartDataDisable, 1);
    check(reqCount - startCount == 1, "R5 no extra request", reqCount - startCount, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(cartDataDisable == 1'b1 && memReq == 1'b0, "R1 reset state",
          {cartDataDisable, memReq}, 2'b10);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(cartDataDisable == 1'b1 && memReq == 1'b0, "R1 after reset",
          {cartDataDisable, memReq}, 2'b10);

    // R3: strobe low while absent
    cartReadN = 1'b0;
    cartAddr = 22'h000100;
    repeat (20) @(negedge clk);
    check(reqCount == 0, "R3 no read while absent", reqCount, 0);
    check(cartDataDisable == 1'b1, "R3 disabled while absent", cartDataDisable, 1);
    cartReadN = 1'b1;
    cartPresent = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      runRead(VECS[i][65:44], int'(VECS[i][43:36]), int'(VECS[i][35:24]), VECS[i][23:0]);
    end

    // R3: presence drop while waiting for ready abandons the read
    begin
      int c0;
      c0 = reqCount;
      busyLeft = 40;
      cartAddr = 22'h000222;
      cartReadN = 1'b0;
      repeat (8) @(negedge clk);
      cartPresent = 1'b0;
      repeat (50) @(negedge clk);
      check(reqCount == c0, "R3 abandoned without request", reqCount - c0, 0);
      check(cartDataDisable == 1'b1, "R3 disabled after drop", cartDataDisable, 1);
      cartReadN = 1'b1;
      cartPresent = 1'b1;
      repeat (4) @(negedge clk);
      runRead(22'h000222, 0, 20, 24'h000222);
    end

    // R8: range select with and without gating
    begin
      int cm, cr;
      cm = reqCount;
      cr = reqCountR;
      cartRangeN = 1'b1;
      cartAddr = 22'h000033;
      cartReadN = 1'b0;
      repeat (20) @(negedge clk);
      check(reqCount - cm == 1, "R8 ungated ignores range", reqCount - cm, 1);
      check(reqCountR == cr, "R8 gated waits for range", reqCountR - cr, 0);
      check(disableR == 1'b1, "R8 gated disable while range high", disableR, 1);
      cartReadN = 1'b1;
      repeat (4) @(negedge clk);
      cartRangeN = 1'b0;
      cartReadN = 1'b0;
      repeat (20) @(negedge clk);
      check(reqCountR - cr == 1, "R8 gated reads with range low", reqCountR - cr, 1);
      check(disableR == 1'b0, "R8 gated enabled with range low", disableR, 0);
      cartReadN = 1'b1;
      cartRangeN = 1'b1;
      repeat (4) @(negedge clk);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule